// File: doc/BRIEF.md
# Streaming Integral Image Generator

The block takes a raster stream of grayscale pixels for one window position of a detection sweep and builds two cumulative tables for that window: the plain integral image and the integral of squared pixels. Each accepted pixel produces one entry of each table in the same cycle it is accepted. The entry is the pixel plus the running sum of its row so far plus the entry directly above it. Only a window of `ROWS` x `COLS` entries is held, 39 x 59 by default. A new window position is loaded by restarting the stream with a start-of-frame flag, which overwrites the store in place.

A classifier or normaliser reads the tables through two ports. The corner port returns both table values at one coordinate one cycle after the request. The rectangle port takes two opposite corners and returns the summed pixels and the summed squared pixels of the enclosed area two cycles after the request. It computes each result from four corner values of the corresponding table.

Top module: `integral_image_gen`

## Requirements
- R1: After a load, the integral entry at window row r and column c (both zero-based) equals the sum of the pixels of the current load in rows 0..r and columns 0..c. It is read through the corner port.
- R2: The squared table entry at (r,c) equals the sum of the squared pixel values over the same area as in R1.
- R3: Table widths are derived from the window size and pixel width. With the defaults they are 20 and 28 bits, so an all-255 window gives 586755 and 149622525 at (38,58) without wrap.
- R4: A pixel with `in_sof_i` set is written at (0,0) and restarts the load. Entries the new load has not yet reached keep their earlier values.
- R5: Row 0 and column 0 of a load take zero as the neighbour above and to the left. No value from an earlier load leaks into them, so after a restart entry (0,0) equals the new pixel alone.
- R6: A pixel with `in_eol_i` closes its row, and the next pixel goes to column 0 of the next row. Once `ROWS` rows are closed, the window is full. While the window is full, and also from reset, `in_ready_o` is low unless `in_sof_i` is high. A pixel that is refused leaves the tables unchanged.
- R7: A pixel offered with `in_sof_i` high is always accepted.
- R8: A corner request on `rd_en_i` at a clock edge gives `rd_vld_o` high for exactly the next cycle, with `rd_ii_o`/`rd_sq_o` holding the entry at (`rd_row_i`,`rd_col_i`).
- R9: A rectangle request at a clock edge gives `rect_vld_o` high exactly two cycles later. The results are I(r1,c1)+I(r0,c0)-I(r0,c1)-I(r1,c0) for each table, taken modulo the table width. This is the pixel sum over rows r0+1..r1 and columns c0+1..c1, and it is zero when r0=r1.
- R10: A read and a table write that fall on the same edge return the value held before that write.
- R11: During reset, `in_ready_o` is low for a non-start pixel, and `rd_vld_o` and `rect_vld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Pixel offered |
| in_ready_o | output | 1 | Pixel taken when valid and ready |
| in_pix_i | input | PIX_W | Grayscale pixel |
| in_sof_i | input | 1 | First pixel of a window load |
| in_eol_i | input | 1 | Last pixel of a row |
| rd_en_i | input | 1 | Corner read request |
| rd_row_i | input | RA_W | Corner row |
| rd_col_i | input | CA_W | Corner column |
| rd_vld_o | output | 1 | Corner data valid |
| rd_ii_o | output | II_W | Integral entry |
| rd_sq_o | output | SQ_W | Squared integral entry |
| rect_req_i | input | 1 | Rectangle sum request |
| rect_r0_i | input | RA_W | Upper corner row (excluded) |
| rect_c0_i | input | CA_W | Left corner column (excluded) |
| rect_r1_i | input | RA_W | Lower corner row (included) |
| rect_c1_i | input | CA_W | Right corner column (included) |
| rect_vld_o | output | 1 | Rectangle result valid |
| rect_sum_o | output | II_W | Pixel sum of the rectangle |
| rect_sqsum_o | output | SQ_W | Squared pixel sum of the rectangle |

## Verification
A table write from the stream and a corner or rectangle read can land on the same entry in the same cycle. The bench provokes this while a window is loading: every seventh streamed pixel is paired with a corner read of the very cell being written, and rectangle requests run on most cycles. A behavioural model updates its table only after it has served that cycle's reads. It therefore expects the old value, and the design's output two edges later is judged against that expectation.

// File: rtl/iig_pkg.sv
package iig_pkg;
  // Bits needed to hold rows*cols*maxval without wrap.
  function automatic int sum_bits(int rows, int cols, int maxval);
    longint m;
    m = longint'(rows) * longint'(cols) * longint'(maxval);
    return $clog2(m + 1);
  endfunction
endpackage

// File: rtl/iig_ctrl.sv
module iig_ctrl #(
  parameter int ROWS = 39,
  parameter int COLS = 59,
  parameter int RA_W = 6,
  parameter int CA_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic            in_sof_i,
  input  logic            in_eol_i,
  output logic            in_ready_o,
  output logic            wr_o,
  output logic [RA_W-1:0] row_o,
  output logic [CA_W-1:0] col_o,
  output logic            first_row_o,
  output logic            first_col_o
);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS + 1);
  localparam logic [RW-1:0] ROWS_C = RW'(ROWS);
  localparam logic [CW-1:0] COLS_C = CW'(COLS);

  logic [RW-1:0] row_q, eff_r;
  logic [CW-1:0] col_q, eff_c;
  logic          full, acc, in_cols;

  assign full       = (row_q == ROWS_C);
  assign in_ready_o = !full || in_sof_i;
  assign acc        = in_valid_i && in_ready_o;
  assign eff_r      = in_sof_i ? '0 : row_q;
  assign eff_c      = in_sof_i ? '0 : col_q;
  assign in_cols    = (eff_c < COLS_C);

  assign wr_o        = acc && in_cols;
  assign row_o       = eff_r[RA_W-1:0];
  assign col_o       = eff_c[CA_W-1:0];
  assign first_row_o = (eff_r == '0);
  assign first_col_o = (eff_c == '0);

  // Reset leaves the window full: only a start pixel opens a load.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= ROWS_C;
      col_q <= '0;
    end else if (acc) begin
      if (in_eol_i) begin
        col_q <= '0;
        row_q <= eff_r + 1'b1;
      end else if (in_cols) begin
        row_q <= eff_r;
        col_q <= eff_c + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iig_accum.sv
module iig_accum #(
  parameter int COLS  = 59,
  parameter int PIX_W = 8,
  parameter int CA_W  = 6,
  parameter int II_W  = 20,
  parameter int SQ_W  = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [CA_W-1:0]  col_i,
  input  logic             first_row_i,
  input  logic             first_col_i,
  output logic [II_W-1:0]  ii_o,
  output logic [SQ_W-1:0]  sq_o
);
  logic [II_W-1:0] line_ii [COLS];
  logic [SQ_W-1:0] line_sq [COLS];
  logic [II_W-1:0] rsum_q, rsum_d, up_ii;
  logic [SQ_W-1:0] rsq_q, rsq_d, up_sq, pix_sq;

  assign pix_sq = SQ_W'(pix_i) * SQ_W'(pix_i);
  assign rsum_d = (first_col_i ? '0 : rsum_q) + II_W'(pix_i);
  assign rsq_d  = (first_col_i ? '0 : rsq_q) + pix_sq;
  assign up_ii  = first_row_i ? '0 : line_ii[col_i];
  assign up_sq  = first_row_i ? '0 : line_sq[col_i];
  assign ii_o   = rsum_d + up_ii;
  assign sq_o   = rsq_d + up_sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsum_q <= '0;
      rsq_q  <= '0;
    end else if (en_i) begin
      rsum_q <= rsum_d;
      rsq_q  <= rsq_d;
    end
  end

  // Previous-row results; contents ignored on row 0.
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      line_ii[col_i] <= ii_o;
      line_sq[col_i] <= sq_o;
    end
  end
endmodule

// File: rtl/iig_store.sv
module iig_store #(
  parameter int ROWS = 39,
  parameter int COLS = 59,
  parameter int RA_W = 6,
  parameter int CA_W = 6,
  parameter int II_W = 20,
  parameter int SQ_W = 28,
  parameter int NRD  = 5
) (
  input  logic            clk_i,
  input  logic            wr_en_i,
  input  logic [RA_W-1:0] wr_row_i,
  input  logic [CA_W-1:0] wr_col_i,
  input  logic [II_W-1:0] wr_ii_i,
  input  logic [SQ_W-1:0] wr_sq_i,
  input  logic [RA_W-1:0] rd_row_i [NRD],
  input  logic [CA_W-1:0] rd_col_i [NRD],
  output logic [II_W-1:0] rd_ii_o  [NRD],
  output logic [SQ_W-1:0] rd_sq_o  [NRD]
);
  logic [II_W-1:0] mem_ii [ROWS][COLS];
  logic [SQ_W-1:0] mem_sq [ROWS][COLS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_ii[wr_row_i][wr_col_i] <= wr_ii_i;
      mem_sq[wr_row_i][wr_col_i] <= wr_sq_i;
    end
  end

  // Registered reads sample the array before a same-edge write lands.
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NRD; p++) begin
      rd_ii_o[p] <= mem_ii[rd_row_i[p]][rd_col_i[p]];
      rd_sq_o[p] <= mem_sq[rd_row_i[p]][rd_col_i[p]];
    end
  end
endmodule

// File: rtl/iig_rect.sv
module iig_rect #(
  parameter int II_W = 20,
  parameter int SQ_W = 28
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [II_W-1:0] br_ii_i,
  input  logic [II_W-1:0] tl_ii_i,
  input  logic [II_W-1:0] tr_ii_i,
  input  logic [II_W-1:0] bl_ii_i,
  input  logic [SQ_W-1:0] br_sq_i,
  input  logic [SQ_W-1:0] tl_sq_i,
  input  logic [SQ_W-1:0] tr_sq_i,
  input  logic [SQ_W-1:0] bl_sq_i,
  output logic            vld_o,
  output logic [II_W-1:0] sum_o,
  output logic [SQ_W-1:0] sqsum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (vld_i) begin
      sum_o   <= (br_ii_i + tl_ii_i) - (tr_ii_i + bl_ii_i);
      sqsum_o <= (br_sq_i + tl_sq_i) - (tr_sq_i + bl_sq_i);
    end
  end
endmodule

// File: rtl/integral_image_gen.sv
module integral_image_gen
  import iig_pkg::*;
#(
  parameter int ROWS  = 39,
  parameter int COLS  = 59,
  parameter int PIX_W = 8,
  localparam int PMAX = (1 << PIX_W) - 1,
  localparam int II_W = sum_bits(ROWS, COLS, PMAX),
  localparam int SQ_W = sum_bits(ROWS, COLS, PMAX * PMAX),
  localparam int RA_W = $clog2(ROWS),
  localparam int CA_W = $clog2(COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] in_pix_i,
  input  logic             in_sof_i,
  input  logic             in_eol_i,
  input  logic             rd_en_i,
  input  logic [RA_W-1:0]  rd_row_i,
  input  logic [CA_W-1:0]  rd_col_i,
  output logic             rd_vld_o,
  output logic [II_W-1:0]  rd_ii_o,
  output logic [SQ_W-1:0]  rd_sq_o,
  input  logic             rect_req_i,
  input  logic [RA_W-1:0]  rect_r0_i,
  input  logic [CA_W-1:0]  rect_c0_i,
  input  logic [RA_W-1:0]  rect_r1_i,
  input  logic [CA_W-1:0]  rect_c1_i,
  output logic             rect_vld_o,
  output logic [II_W-1:0]  rect_sum_o,
  output logic [SQ_W-1:0]  rect_sqsum_o
);
  // Store read ports: 0..3 rectangle corners, 4 corner port.
  localparam int NRD   = 5;
  localparam int P_BR  = 0;
  localparam int P_TL  = 1;
  localparam int P_TR  = 2;
  localparam int P_BL  = 3;
  localparam int P_RD  = 4;

  logic            wr_en, first_r, first_c;
  logic [RA_W-1:0] wr_row;
  logic [CA_W-1:0] wr_col;
  logic [II_W-1:0] wr_ii;
  logic [SQ_W-1:0] wr_sq;
  logic [RA_W-1:0] s_row [NRD];
  logic [CA_W-1:0] s_col [NRD];
  logic [II_W-1:0] s_ii  [NRD];
  logic [SQ_W-1:0] s_sq  [NRD];
  logic            req_q, rd_vld_q;

  iig_ctrl #(.ROWS(ROWS), .COLS(COLS), .RA_W(RA_W), .CA_W(CA_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_sof_i   (in_sof_i),
    .in_eol_i   (in_eol_i),
    .in_ready_o (in_ready_o),
    .wr_o       (wr_en),
    .row_o      (wr_row),
    .col_o      (wr_col),
    .first_row_o(first_r),
    .first_col_o(first_c)
  );

  iig_accum #(.COLS(COLS), .PIX_W(PIX_W), .CA_W(CA_W), .II_W(II_W), .SQ_W(SQ_W)) i_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (wr_en),
    .pix_i      (in_pix_i),
    .col_i      (wr_col),
    .first_row_i(first_r),
    .first_col_i(first_c),
    .ii_o       (wr_ii),
    .sq_o       (wr_sq)
  );

  assign s_row[P_BR] = rect_r1_i;  assign s_col[P_BR] = rect_c1_i;
  assign s_row[P_TL] = rect_r0_i;  assign s_col[P_TL] = rect_c0_i;
  assign s_row[P_TR] = rect_r0_i;  assign s_col[P_TR] = rect_c1_i;
  assign s_row[P_BL] = rect_r1_i;  assign s_col[P_BL] = rect_c0_i;
  assign s_row[P_RD] = rd_row_i;   assign s_col[P_RD] = rd_col_i;

  iig_store #(
    .ROWS(ROWS), .COLS(COLS), .RA_W(RA_W), .CA_W(CA_W),
    .II_W(II_W), .SQ_W(SQ_W), .NRD(NRD)
  ) i_store (
    .clk_i   (clk_i),
    .wr_en_i (wr_en),
    .wr_row_i(wr_row),
    .wr_col_i(wr_col),
    .wr_ii_i (wr_ii),
    .wr_sq_i (wr_sq),
    .rd_row_i(s_row),
    .rd_col_i(s_col),
    .rd_ii_o (s_ii),
    .rd_sq_o (s_sq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      req_q    <= rect_req_i;
      rd_vld_q <= rd_en_i;
    end
  end

  assign rd_vld_o = rd_vld_q;
  assign rd_ii_o  = s_ii[P_RD];
  assign rd_sq_o  = s_sq[P_RD];

  iig_rect #(.II_W(II_W), .SQ_W(SQ_W)) i_rect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (req_q),
    .br_ii_i(s_ii[P_BR]),
    .tl_ii_i(s_ii[P_TL]),
    .tr_ii_i(s_ii[P_TR]),
    .bl_ii_i(s_ii[P_BL]),
    .br_sq_i(s_sq[P_BR]),
    .tl_sq_i(s_sq[P_TL]),
    .tr_sq_i(s_sq[P_TR]),
    .bl_sq_i(s_sq[P_BL]),
    .vld_o  (rect_vld_o),
    .sum_o  (rect_sum_o),
    .sqsum_o(rect_sqsum_o)
  );
endmodule

// File: rtl/iig_checker.sv
module iig_checker #(
  parameter int II_W = 20,
  parameter int SQ_W = 28
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_sof_i,
  input logic            in_ready_o,
  input logic            rd_en_i,
  input logic            rd_vld_o,
  input logic            rect_req_i,
  input logic            rect_vld_o,
  input logic            wr_en_i,
  input logic [II_W-1:0] wr_ii_i,
  input logic [SQ_W-1:0] wr_sq_i
);
  p_sof_taken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_sof_i |-> in_ready_o);

  p_rd_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_vld_o);

  p_rd_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(rd_en_i));

  p_rect_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_req_i |=> ##1 rect_vld_o);

  p_rect_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_vld_o |-> $past(rect_req_i, 2));

  // p*p >= p for every pixel, so the squared entry never trails the plain one (R2).
  p_sq_ge_ii_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_sq_i >= SQ_W'(wr_ii_i)));
endmodule

bind integral_image_gen iig_checker #(.II_W(II_W), .SQ_W(SQ_W)) i_iig_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_sof_i  (in_sof_i),
  .in_ready_o(in_ready_o),
  .rd_en_i   (rd_en_i),
  .rd_vld_o  (rd_vld_o),
  .rect_req_i(rect_req_i),
  .rect_vld_o(rect_vld_o),
  .wr_en_i   (wr_en),
  .wr_ii_i   (wr_ii),
  .wr_sq_i   (wr_sq)
);

// File: tb/test_integral_image_gen.sv
`timescale 1ns/1ps
module test_integral_image_gen;
  localparam int ROWS = 39;
  localparam int COLS = 59;
  localparam int IIW  = 20;
  localparam int SQW  = 28;
  localparam longint IIM = (64'd1 << IIW) - 1;
  localparam longint SQM = (64'd1 << SQW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           in_valid = 0, in_sof = 0, in_eol = 0, in_ready;
  logic [7:0]     in_pix = 0;
  logic           rd_en = 0, rd_vld;
  logic [5:0]     rd_row = 0, rd_col = 0;
  logic [IIW-1:0] rd_ii;
  logic [SQW-1:0] rd_sq;
  logic           rect_req = 0, rect_vld;
  logic [5:0]     r0 = 0, c0 = 0, r1 = 0, c1 = 0;
  logic [IIW-1:0] rect_sum;
  logic [SQW-1:0] rect_sq;

  integer n_chk = 0, n_bad = 0;
  string  phase = "R11";

  integral_image_gen i_integral_image_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pix_i(in_pix),
    .in_sof_i(in_sof), .in_eol_i(in_eol),
    .rd_en_i(rd_en), .rd_row_i(rd_row), .rd_col_i(rd_col),
    .rd_vld_o(rd_vld), .rd_ii_o(rd_ii), .rd_sq_o(rd_sq),
    .rect_req_i(rect_req), .rect_r0_i(r0), .rect_c0_i(c0),
    .rect_r1_i(r1), .rect_c1_i(c1),
    .rect_vld_o(rect_vld), .rect_sum_o(rect_sum), .rect_sqsum_o(rect_sq)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (phase %s)", tag, act, exp, phase);
    end
  endtask

  // Behavioural model: pixel grid and tables by definition.
  int     mpix [ROWS][COLS];
  longint mii  [ROWS][COLS];
  longint msq  [ROWS][COLS];
  int     mrow = ROWS, mcol = 0, pr, pc;
  longint acc_s, acc_q;
  bit     erd_v = 0, q1v = 0, q2v = 0;
  longint erd_ii, erd_sq, q1s, q1q, q2s, q2q;

  always @(posedge clk) begin
    if (!rst_n) begin
      mrow = ROWS; mcol = 0; erd_v = 0; q1v = 0; q2v = 0;
    end else begin
      // reads first: they see the tables before this edge's write (R10)
      erd_v = rd_en;
      if (rd_en) begin
        erd_ii = mii[rd_row][rd_col];
        erd_sq = msq[rd_row][rd_col];
      end
      q2v = q1v; q2s = q1s; q2q = q1q;
      q1v = rect_req;
      if (rect_req) begin
        q1s = (mii[r1][c1] + mii[r0][c0] - mii[r0][c1] - mii[r1][c0]) & IIM;
        q1q = (msq[r1][c1] + msq[r0][c0] - msq[r0][c1] - msq[r1][c0]) & SQM;
      end
      if (in_valid && ((mrow < ROWS) || in_sof)) begin
        pr = in_sof ? 0 : mrow;
        pc = in_sof ? 0 : mcol;
        if (pc < COLS) begin
          mpix[pr][pc] = int'(in_pix);
          acc_s = 0; acc_q = 0;
          for (int rr = 0; rr <= pr; rr++)
            for (int cc = 0; cc <= pc; cc++) begin
              acc_s += mpix[rr][cc];
              acc_q += longint'(mpix[rr][cc]) * mpix[rr][cc];
            end
          mii[pr][pc] = acc_s;
          msq[pr][pc] = acc_q;
        end
        if (in_eol) begin
          mcol = 0; mrow = pr + 1;
        end else if (pc < COLS) begin
          mrow = pr; mcol = pc + 1;
        end
      end
    end
  end

  // Compared on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_sof) check(in_ready === (in_valid || 1'b1), "R7 ready on start pixel", in_ready, 1);
      else        check(in_ready === (mrow < ROWS), "R6 ready", in_ready, (mrow < ROWS));
      check(rd_vld === erd_v, "R8 rd_vld", rd_vld, erd_v);
      if (erd_v) begin
        check(longint'(rd_ii) == erd_ii, "R1 corner ii", rd_ii, erd_ii);
        check(longint'(rd_sq) == erd_sq, "R2 corner sq", rd_sq, erd_sq);
      end
      check(rect_vld === q2v, "R9 rect_vld", rect_vld, q2v);
      if (q2v) begin
        check(longint'(rect_sum) == q2s, "R9 rect sum", rect_sum, q2s);
        check(longint'(rect_sq) == q2q, "R9 rect sqsum", rect_sq, q2q);
      end
    end
  end

  function automatic int pat(int kind, int r, int c);
    case (kind)
      0:       return (r * 7 + c * 3 + 1) % 256;
      1:       return 255;
      default: return (r * c + 5) % 256;
    endcase
  endfunction

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eol = 0; rd_en = 0; rect_req = 0;
  endtask

  task automatic send_window(int kind, int nrows);
    int a, b;
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++) begin
        @(posedge clk); #1;
        in_valid = 1;
        in_pix   = 8'(pat(kind, r, c));
        in_sof   = (r == 0 && c == 0);
        in_eol   = (c == COLS - 1);
        rd_en    = ((r + c) % 3 == 0) || ((r + c) % 7 == 0);
        if ((r + c) % 7 == 0) begin  // same cell as this cycle's write (R10)
          rd_row = 6'(r); rd_col = 6'(c);
        end else begin
          rd_row = 6'((r * 5 + c) % ROWS); rd_col = 6'((c * 11 + r) % COLS);
        end
        rect_req = (c % 4 != 0);
        a = (r * 3 + c) % ROWS; b = (c * 7 + r) % ROWS;
        r0 = 6'((a < b) ? a : b); r1 = 6'((a < b) ? b : a);
        a = (c * 5 + r) % COLS; b = (r * 9 + c) % COLS;
        c0 = 6'((a < b) ? a : b); c1 = 6'((a < b) ? b : a);
      end
    idle();
  endtask

  task automatic sweep();
    for (int k = 0; k < ROWS * COLS; k++) begin
      @(posedge clk); #1;
      in_valid = 0; rd_en = 1;
      rd_row = 6'(k / COLS); rd_col = 6'(k % COLS);
      rect_req = 1;
      r1 = 6'(k / COLS); c1 = 6'(k % COLS);
      r0 = (k % 3 == 0) ? r1 : 6'((k / COLS) / 2);
      c0 = 6'((k % COLS) / 3);
    end
    @(posedge clk); #1;
    rd_en = 0; r0 = 0; c0 = 0; r1 = 6'(ROWS - 1); c1 = 6'(COLS - 1);
    idle();
    repeat (3) idle();
  endtask

  task automatic read_cell(int r, int c, output longint ii, output longint sq);
    @(posedge clk); #1;
    in_valid = 0; rect_req = 0; rd_en = 1; rd_row = 6'(r); rd_col = 6'(c);
    @(posedge clk); #1;
    rd_en = 0;
    @(negedge clk);
    ii = rd_ii; sq = rd_sq;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    longint vi, vs;
    repeat (3) @(posedge clk);
    #1 in_valid = 1; in_pix = 8'd9; in_sof = 0;
    @(negedge clk);
    check(in_ready === 1'b0, "R11 ready in reset", in_ready, 0);
    check(rd_vld === 1'b0, "R11 rd_vld in reset", rd_vld, 0);
    check(rect_vld === 1'b0, "R11 rect_vld in reset", rect_vld, 0);
    @(posedge clk); #1 rst_n = 1;
    phase = "R6 after reset";
    repeat (4) @(posedge clk);
    idle();

    phase = "R1";
    send_window(0, ROWS);
    phase = "R6 full window";
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sof = 0; in_eol = (i == 4); in_pix = 8'd200;
    end
    idle();
    sweep();

    phase = "R3";
    send_window(1, ROWS);
    read_cell(ROWS - 1, COLS - 1, vi, vs);
    check(vi == 586755, "R3 full-window ii", vi, 586755);
    check(vs == 149622525, "R3 full-window sq", vs, 149622525);

    phase = "R4";
    send_window(2, 3);
    read_cell(0, 0, vi, vs);
    check(vi == 5, "R5 restart corner ii", vi, 5);
    check(vs == 25, "R5 restart corner sq", vs, 25);
    read_cell(10, 10, vi, vs);
    check(vi == 30855, "R4 untouched entry kept", vi, 30855);
    sweep();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule